// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Wakeup

The block collects level-sensitive interrupt requests from `NUM_SRC` peripheral sources, each with a fixed level and a fixed rank, and gives the processor core the winning level and vector number. Source 0 is the non-maskable source at level 7. The other sources fall into groups of `LVL_GROUP` consecutive sources, and each group sits one level below the group before it. Software can move up to two chosen sources to the top maskable level (6), where they rank above every native level-6 source. Software can also raise any source through a force set/clear pair as if its line were asserted.

Software reaches the block with byte reads and writes in a 64-byte window at the top of a 24-bit address space. A read of a per-level acknowledge register returns the vector that would be taken at that level. An access to a reserved offset, or one the target register does not support, ends with a bus error instead of an acknowledge. The response state machine has three states:
- `BUS_IDLE`: no response.
- `BUS_DONE`: acknowledge.
- `BUS_FAULT`: bus error.

From any state, a selected access inside the window moves the machine to `BUS_DONE` if the access is legal and to `BUS_FAULT` if it is not. Any other cycle returns it to `BUS_IDLE`.

While the low-power enable is high, a purely combinational path drives the wakeup output from the request lines, the force bits and the core mask. This path needs no clock.

Top module: `prio_intc`

## Requirements
- R1: After reset, `irq_lvl`, `irq_vec`, `bus_rdata`, `bus_ack` and `bus_berr` are zero, all force bits are clear, and both remap slots read 0.
- R2: An access is in the window only when `bus_addr[23:6]` is all ones. Such an access gets exactly one of `bus_ack` or `bus_berr` in the next cycle. Any other cycle gives neither, and an access outside the window changes no state.
- R3: These accesses answer with `bus_berr` and change no state: any offset other than 0x00–0x01, 0x10–0x13 and 0x21–0x27 (including 0x20); a write to 0x00/0x01 or to 0x21–0x27; a read of 0x10/0x11.
- R4: The vector for source s equals 62 plus its legacy index s+2, that is 64+s. When no request wins, `irq_lvl` and `irq_vec` are 0.
- R5: Source 0 has level 7. Source s≥1 has level 6−(s−1)/3 (integer division), never lower than 1.
- R6: A request takes part only when its effective level is greater than `core_mask`, except that level 7 always takes part.
- R7: Among the requests that take part, the highest effective level wins. Within level 7 and among native sources of one level, the lower source number wins. Remapped sources have effective level 6 and rank above native level-6 sources, with slot 1 ahead of slot 2.
- R8: Remap slot 1 is at offset 0x12 and slot 2 at 0x13. Both are read/write and hold a source number; 0 means unused. Writing a value of `NUM_SRC` or more gives `bus_berr` and leaves the slot unchanged.
- R9: A write of source number n to 0x10 sets force bit n, and a write to 0x11 clears it. A value of `NUM_SRC` or more gives `bus_berr` and changes nothing. Force bit n reads at bit n%8 of offset n/8, and a set force bit acts as a request on line n.
- R10: A read of offset 0x20+L (L=1..7) returns the vector of the top-ranked pending source whose effective level is L, ignoring `core_mask`, or 0 if there is none. `bus_rdata` is 0 in every cycle without a read acknowledge.
- R11: `irq_lvl` and `irq_vec` are registered. They reflect the request lines, force bits, remap slots and mask of the previous clock edge.
- R12: `wake` = `lp_en` AND (some pending request takes part under R6/R7). It follows the inputs combinationally with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_ack | output | 1 | Normal completion, cycle after the access |
| bus_berr | output | 1 | Error completion, cycle after the access |
| bus_rdata | output | 8 | Read data, valid with `bus_ack` |
| irq_src | input | NUM_SRC | Level request lines |
| core_mask | input | 3 | Current core mask level |
| irq_lvl | output | 3 | Winning level, 0 = none |
| irq_vec | output | 8 | Winning vector, 0 = none |
| lp_en | input | 1 | Low-power monitoring enable |
| wake | output | 1 | Combinational wakeup request |

## Verification
Every result is due at a fixed distance from its cause.
- The level and vector move one edge after a request, mask, force or remap change.
- A bus response and its read data appear after the edge that took the access.
- `wake` follows its inputs in the same cycle.

The bench drives inputs one time step after the falling edge and updates its reference model at each rising edge from the values in force before that edge. At every falling edge it compares all outputs, so a response one cycle early or late shows up as a miscompare.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_DONE  = 2'd1,
        BUS_FAULT = 2'd2
    } bus_state_e;

    typedef struct packed {
        logic       hit;
        logic [2:0] lvl;
        logic [7:0] vec;
    } pick_t;

    localparam logic [2:0] LVL_NMI  = 3'd7;
    localparam logic [2:0] LVL_TOPM = 3'd6;

    localparam logic [5:0] OFS_FSET = 6'h10;
    localparam logic [5:0] OFS_FCLR = 6'h11;
    localparam logic [5:0] OFS_MAP1 = 6'h12;
    localparam logic [5:0] OFS_MAP2 = 6'h13;
    localparam logic [2:0] OFS_ACKG = 3'b100;

    localparam int VEC_OFFSET = 62;

    // fixed level of a source: source 0 is non-maskable, then groups step down
    function automatic logic [2:0] fixed_level(input int src, input int grp);
        int t;
        if (src == 0) return LVL_NMI;
        t = 6 - (src - 1) / grp;
        if (t < 1) t = 1;
        return 3'(t);
    endfunction

endpackage

// File: rtl/intc_arb.sv
`timescale 1ns/1ps
module intc_arb
    import intc_pkg::*;
#(
    parameter int NUM_SRC   = 16,
    parameter int LVL_GROUP = 3,
    parameter int IDX_BASE  = 2,
    localparam int SW       = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [2:0]         mask,
    input  logic [SW-1:0]      map1,
    input  logic [SW-1:0]      map2,
    output pick_t              win,
    output logic [7:1][7:0]    ack_vec
);

    function automatic logic [7:0] vec_of(input int s);
        return 8'(VEC_OFFSET + IDX_BASE + s);
    endfunction

    function automatic logic qual(input logic [2:0] l, input logic exact, input logic [2:0] key);
        return exact ? (l == key) : ((l == LVL_NMI) || (l > key));
    endfunction

    // ordered scan: level 7 natives, slot 1, slot 2, remaining natives by number
    function automatic pick_t pick(input logic [NUM_SRC-1:0] p, input logic [SW-1:0] m1,
                                   input logic [SW-1:0] m2, input logic exact,
                                   input logic [2:0] key);
        pick_t r;
        logic  rm;
        r = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (!r.hit && p[s] && fixed_level(s, LVL_GROUP) == LVL_NMI && qual(LVL_NMI, exact, key))
                r = '{hit: 1'b1, lvl: LVL_NMI, vec: vec_of(s)};
        end
        if (!r.hit && m1 != '0 && p[m1] && qual(LVL_TOPM, exact, key))
            r = '{hit: 1'b1, lvl: LVL_TOPM, vec: vec_of(int'(m1))};
        if (!r.hit && m2 != '0 && p[m2] && qual(LVL_TOPM, exact, key))
            r = '{hit: 1'b1, lvl: LVL_TOPM, vec: vec_of(int'(m2))};
        for (int s = 0; s < NUM_SRC; s++) begin
            rm = (m1 != '0 && m1 == SW'(s)) || (m2 != '0 && m2 == SW'(s));
            if (!r.hit && !rm && p[s] && fixed_level(s, LVL_GROUP) != LVL_NMI &&
                qual(fixed_level(s, LVL_GROUP), exact, key))
                r = '{hit: 1'b1, lvl: fixed_level(s, LVL_GROUP), vec: vec_of(s)};
        end
        return r;
    endfunction

    always_comb win = pick(pend, map1, map2, 1'b0, mask);

    for (genvar L = 1; L < 8; L++) begin : g_iack
        pick_t r;
        assign r          = pick(pend, map1, map2, 1'b1, 3'(L));
        assign ack_vec[L] = (r.hit && r.lvl == 3'(L)) ? r.vec : 8'h00;
    end

endmodule

// File: rtl/intc_regs.sv
`timescale 1ns/1ps
module intc_regs
    import intc_pkg::*;
#(
    parameter int NUM_SRC   = 16,
    localparam int SW       = $clog2(NUM_SRC),
    localparam int FRC_BYTES = (NUM_SRC + 7) / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [23:0]        bus_addr,
    input  logic [7:0]         bus_wdata,
    input  logic [7:1][7:0]    ack_vec,
    output logic               bus_ack,
    output logic               bus_berr,
    output logic [7:0]         bus_rdata,
    output logic [NUM_SRC-1:0] frc_q,
    output logic [SW-1:0]      map1_q,
    output logic [SW-1:0]      map2_q
);

    bus_state_e st_q, st_d;
    logic                   hit;
    logic [5:0]             ofs;
    logic                   wdat_ok;
    logic                   acc_ok;
    logic [7:0]             rd_val;
    logic [FRC_BYTES*8-1:0] frc_pad;
    logic [SW-1:0]          widx;

    assign hit     = bus_sel && (&bus_addr[23:6]);
    assign ofs     = bus_addr[5:0];
    assign wdat_ok = ({1'b0, bus_wdata} < 9'(NUM_SRC));
    assign widx    = bus_wdata[SW-1:0];

    always_comb begin
        frc_pad = '0;
        frc_pad[NUM_SRC-1:0] = frc_q;
    end

    // offset decode: legality and read value
    always_comb begin
        acc_ok = 1'b0;
        rd_val = 8'h00;
        if (ofs < 6'(FRC_BYTES)) begin
            acc_ok = !bus_wr;
            for (int b = 0; b < FRC_BYTES; b++)
                if (ofs == 6'(b)) rd_val = frc_pad[b*8 +: 8];
        end else if (ofs == OFS_FSET || ofs == OFS_FCLR) begin
            acc_ok = bus_wr && wdat_ok;
        end else if (ofs == OFS_MAP1) begin
            acc_ok = !bus_wr || wdat_ok;
            rd_val = 8'(map1_q);
        end else if (ofs == OFS_MAP2) begin
            acc_ok = !bus_wr || wdat_ok;
            rd_val = 8'(map2_q);
        end else if (ofs[5:3] == OFS_ACKG && ofs[2:0] != 3'd0) begin
            acc_ok = !bus_wr;
            rd_val = ack_vec[ofs[2:0]];
        end
    end

    // next-state logic
    always_comb begin
        st_d = BUS_IDLE;
        unique case (st_q)
            BUS_IDLE, BUS_DONE, BUS_FAULT: begin
                if (hit) st_d = acc_ok ? BUS_DONE : BUS_FAULT;
            end
            default: st_d = BUS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BUS_IDLE;
        else        st_q <= st_d;
    end

    // state outputs
    always_comb begin
        bus_ack  = 1'b0;
        bus_berr = 1'b0;
        unique case (st_q)
            BUS_DONE:  bus_ack  = 1'b1;
            BUS_FAULT: bus_berr = 1'b1;
            BUS_IDLE:  ;
            default:   ;
        endcase
    end

    // register file and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frc_q     <= '0;
            map1_q    <= '0;
            map2_q    <= '0;
            bus_rdata <= 8'h00;
        end else begin
            bus_rdata <= (hit && acc_ok && !bus_wr) ? rd_val : 8'h00;
            if (hit && acc_ok && bus_wr) begin
                if (ofs == OFS_FSET) frc_q[widx] <= 1'b1;
                if (ofs == OFS_FCLR) frc_q[widx] <= 1'b0;
                if (ofs == OFS_MAP1) map1_q <= widx;
                if (ofs == OFS_MAP2) map2_q <= widx;
            end
        end
    end

endmodule

// File: rtl/prio_intc.sv
`timescale 1ns/1ps
module prio_intc
    import intc_pkg::*;
#(
    parameter int NUM_SRC   = 16,
    parameter int LVL_GROUP = 3,
    parameter int IDX_BASE  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [23:0]        bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic               bus_ack,
    output logic               bus_berr,
    output logic [7:0]         bus_rdata,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic [2:0]         core_mask,
    output logic [2:0]         irq_lvl,
    output logic [7:0]         irq_vec,
    input  logic               lp_en,
    output logic               wake
);

    localparam int SW = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] frc_q;
    logic [NUM_SRC-1:0] pend;
    logic [SW-1:0]      map1_q;
    logic [SW-1:0]      map2_q;
    logic [7:1][7:0]    ack_vec;
    pick_t              win;

    assign pend = irq_src | frc_q;

    intc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ack_vec   (ack_vec),
        .bus_ack   (bus_ack),
        .bus_berr  (bus_berr),
        .bus_rdata (bus_rdata),
        .frc_q     (frc_q),
        .map1_q    (map1_q),
        .map2_q    (map2_q)
    );

    intc_arb #(.NUM_SRC(NUM_SRC), .LVL_GROUP(LVL_GROUP), .IDX_BASE(IDX_BASE)) u_arb (
        .pend    (pend),
        .mask    (core_mask),
        .map1    (map1_q),
        .map2    (map2_q),
        .win     (win),
        .ack_vec (ack_vec)
    );

    // registered core-facing outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_lvl <= 3'd0;
            irq_vec <= 8'h00;
        end else begin
            irq_lvl <= win.lvl;
            irq_vec <= win.vec;
        end
    end

    // clockless wakeup path
    assign wake = lp_en && win.hit;

endmodule

// File: rtl/prio_intc_chk.sv
`timescale 1ns/1ps
module prio_intc_chk #(
    parameter int NUM_SRC  = 16,
    parameter int IDX_BASE = 2,
    localparam int SW      = $clog2(NUM_SRC),
    localparam int VEC_LO  = 62 + IDX_BASE
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic [23:0]   bus_addr,
    input logic          bus_ack,
    input logic          bus_berr,
    input logic [2:0]    core_mask,
    input logic [2:0]    irq_lvl,
    input logic [7:0]    irq_vec,
    input logic          lp_en,
    input logic          wake,
    input logic [SW-1:0] map1_q,
    input logic [SW-1:0] map2_q
);

    // R2: in-window access gets exactly one response next cycle
    a_r2_one_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && (&bus_addr[23:6])) |=> (bus_ack != bus_berr));

    // R2: no access, no response
    a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && (&bus_addr[23:6])) |=> (!bus_ack && !bus_berr));

    // R3: acknowledge and error never together
    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ack && bus_berr));

    // R6: a maskable winner was above the mask of the previous edge
    a_r6_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl != 3'd0 && irq_lvl != 3'd7) |-> (irq_lvl > $past(core_mask)));

    // R4: vector range when a request wins
    a_r4_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl != 3'd0) |-> (irq_vec >= 8'(VEC_LO) && irq_vec < 8'(VEC_LO + NUM_SRC)));

    // R4: nothing winning presents vector 0
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl == 3'd0) |-> (irq_vec == 8'h00));

    // R12: no wakeup without the low-power enable
    a_r12_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_en |-> !wake);

    // R8: remap slots never hold an out-of-range source
    a_r8_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, map1_q} < (SW+1)'(NUM_SRC)) && ({1'b0, map2_q} < (SW+1)'(NUM_SRC)));

endmodule

bind prio_intc prio_intc_chk #(.NUM_SRC(NUM_SRC), .IDX_BASE(IDX_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_addr  (bus_addr),
    .bus_ack   (bus_ack),
    .bus_berr  (bus_berr),
    .core_mask (core_mask),
    .irq_lvl   (irq_lvl),
    .irq_vec   (irq_vec),
    .lp_en     (lp_en),
    .wake      (wake),
    .map1_q    (map1_q),
    .map2_q    (map2_q)
);

// File: tb/prio_intc_tb.sv
`timescale 1ns/1ps
module prio_intc_tb;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel = 1'b0;
    logic         wr = 1'b0;
    logic [23:0]  addr = '0;
    logic [7:0]   wdata = '0;
    logic [N-1:0] irq_src = '0;
    logic [2:0]   core_mask = '0;
    logic         lp_en = 1'b0;
    wire          bus_ack, bus_berr, wake;
    wire  [7:0]   bus_rdata, irq_vec;
    wire  [2:0]   irq_lvl;

    always #4 clk = ~clk;

    prio_intc u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_ack(bus_ack), .bus_berr(bus_berr), .bus_rdata(bus_rdata),
        .irq_src(irq_src), .core_mask(core_mask), .irq_lvl(irq_lvl), .irq_vec(irq_vec),
        .lp_en(lp_en), .wake(wake)
    );

    int    vecs = 0, errs = 0;
    string tag = "R1";

    // reference state
    logic [N-1:0] m_frc = '0;
    int           m_map1 = 0, m_map2 = 0;
    int           m_lvl = 0, m_vec = 0;
    logic         m_ack = 0, m_berr = 0;
    int           m_rd = 0;

    function automatic int nat_lvl(int s);
        int t;
        if (s == 0) return 7;
        t = 6 - (s - 1) / 3;
        return (t < 1) ? 1 : t;
    endfunction

    // score-based selection: highest score among qualifying pending sources
    function automatic void choose(input logic [N-1:0] p, input int r1, input int r2,
                                   input bit exact, input int key,
                                   output int lvl, output int vec);
        int best = -1, e, sc;
        bit q;
        lvl = 0; vec = 0;
        for (int s = 0; s < N; s++) begin
            if (!p[s]) continue;
            if (s == 0)            begin e = 7; sc = 700; end
            else if (s == r1)      begin e = 6; sc = 690; end
            else if (s == r2)      begin e = 6; sc = 680; end
            else                   begin e = nat_lvl(s); sc = e * 100 + 50 - s; end
            q = exact ? (e == key) : (e == 7 || e > key);
            if (q && sc > best) begin best = sc; lvl = e; vec = 64 + s; end
        end
    endfunction

    always @(posedge clk) begin : model
        int nl, nv, o, d;
        logic [N-1:0] p;
        if (!rst_n) begin
            m_frc = '0; m_map1 = 0; m_map2 = 0; m_lvl = 0; m_vec = 0;
            m_ack = 0; m_berr = 0; m_rd = 0;
        end else begin
            p = irq_src | m_frc;
            choose(p, m_map1, m_map2, 0, int'(core_mask), nl, nv);
            m_ack = 0; m_berr = 0; m_rd = 0;
            if (sel && addr[23:6] == 18'h3FFFF) begin
                o = int'(addr[5:0]); d = int'(wdata);
                if (o <= 1) begin
                    if (wr) m_berr = 1;
                    else begin m_ack = 1; m_rd = int'(m_frc[o*8 +: 8]); end
                end else if (o == 16 || o == 17) begin
                    if (!wr || d >= N) m_berr = 1;
                    else begin m_ack = 1; m_frc[d] = (o == 16); end
                end else if (o == 18 || o == 19) begin
                    if (!wr) begin m_ack = 1; m_rd = (o == 18) ? m_map1 : m_map2; end
                    else if (d >= N) m_berr = 1;
                    else begin
                        m_ack = 1;
                        if (o == 18) m_map1 = d; else m_map2 = d;
                    end
                end else if (o >= 33 && o <= 39) begin
                    if (wr) m_berr = 1;
                    else begin
                        int il, iv;
                        choose(p, m_map1, m_map2, 1, o - 32, il, iv);
                        m_ack = 1; m_rd = iv;
                    end
                end else m_berr = 1;
            end
            m_lvl = nl; m_vec = nv;
        end
    end

    task automatic cmp(string what, int act, int exp);
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare everything away from the active edge
    always @(negedge clk) begin : checker_blk
        int wl, wv;
        vecs++;
        cmp("irq_lvl", int'(irq_lvl), m_lvl);
        cmp("irq_vec", int'(irq_vec), m_vec);
        cmp("bus_ack", int'(bus_ack), int'(m_ack));
        cmp("bus_berr", int'(bus_berr), int'(m_berr));
        cmp("bus_rdata", int'(bus_rdata), m_rd);
        choose(irq_src | m_frc, m_map1, m_map2, 0, int'(core_mask), wl, wv);
        cmp("wake", int'(wake), int'(lp_en && wl != 0));
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_in(logic [N-1:0] s, logic [2:0] m);
        @(negedge clk); #1;
        irq_src = s; core_mask = m;
    endtask

    task automatic bus_at(logic w, logic [23:0] a, logic [7:0] d);
        @(negedge clk); #1;
        sel = 1; wr = w; addr = a; wdata = d;
        @(negedge clk); #1;
        sel = 0; wr = 0;
    endtask

    task automatic bus(logic w, logic [5:0] o, logic [7:0] d);
        bus_at(w, {18'h3FFFF, o}, d);
    endtask

    initial begin : watchdog
        #(8 * 60000);
        errs++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin : stim
        idle(4); #1 rst_n = 1;
        // R1: reset values through the register interface
        tag = "R1";
        bus(0, 6'h00, 0); bus(0, 6'h01, 0); bus(0, 6'h12, 0); bus(0, 6'h13, 0);
        idle(2);
        // R4 / R5: each source alone gives its vector and level
        tag = "R5";
        for (int s = 0; s < N; s++) begin set_in(16'(1 << s), 3'd0); idle(1); end
        tag = "R4";
        set_in('0, 3'd0); idle(2);
        // R6: masking
        tag = "R6";
        set_in(16'(1 << 10), 3'd3); idle(2);
        set_in(16'(1 << 10), 3'd2); idle(2);
        set_in(16'(1 << 1), 3'd6);  idle(2);
        set_in(16'(1 << 1), 3'd5);  idle(2);
        set_in(16'h0001, 3'd7);     idle(2);
        set_in(16'h8421, 3'd4);     idle(2);
        // R7: fixed priority
        tag = "R7";
        set_in(16'h0E0E, 3'd0); idle(2);
        set_in(16'hFFFE, 3'd0); idle(2);
        set_in(16'hFFFF, 3'd0); idle(2);
        set_in(16'hC000, 3'd1); idle(2);
        // R8: remap slots
        tag = "R8";
        bus(1, 6'h12, 8'd12); bus(1, 6'h13, 8'd5);
        bus(0, 6'h12, 0); bus(0, 6'h13, 0);
        bus(1, 6'h12, 8'd16); bus(1, 6'h13, 8'd255);
        bus(0, 6'h12, 0); bus(0, 6'h13, 0);
        set_in(16'h1022, 3'd0); idle(2);
        set_in(16'h0022, 3'd0); idle(2);
        set_in(16'h0002, 3'd0); idle(2);
        set_in(16'h1021, 3'd0); idle(2);
        set_in(16'h1000, 3'd5); idle(2);
        bus(1, 6'h13, 8'd12); set_in(16'h1002, 3'd0); idle(2);
        bus(1, 6'h12, 8'd0); bus(1, 6'h13, 8'd0); idle(2);
        // R9: force set/clear
        tag = "R9";
        set_in('0, 3'd0);
        bus(1, 6'h10, 8'd7);  idle(2); bus(0, 6'h00, 0);
        bus(1, 6'h10, 8'd15); idle(2); bus(0, 6'h01, 0);
        bus(1, 6'h11, 8'd7);  idle(2); bus(0, 6'h00, 0);
        bus(1, 6'h10, 8'd16); bus(1, 6'h11, 8'd200); bus(0, 6'h01, 0);
        // R3: illegal accesses
        tag = "R3";
        bus(0, 6'h10, 0); bus(0, 6'h11, 0);
        bus(1, 6'h00, 8'hFF); bus(1, 6'h01, 8'h00); bus(1, 6'h21, 8'h3);
        bus(0, 6'h02, 0); bus(0, 6'h14, 0); bus(0, 6'h20, 0); bus(1, 6'h20, 0);
        bus(0, 6'h28, 0); bus(0, 6'h3F, 0); bus(0, 6'h08, 0);
        bus(0, 6'h00, 0); bus(0, 6'h01, 0);
        // R2: outside the window nothing responds or changes
        tag = "R2";
        bus_at(1, 24'hFFFF92, 8'd3); bus_at(0, 24'h7FFFC0, 0); bus_at(1, 24'h000010, 8'd2);
        idle(2); bus(0, 6'h12, 0); bus(0, 6'h00, 0);
        // R10: software acknowledge per level
        tag = "R10";
        bus(1, 6'h12, 8'd9); bus(1, 6'h10, 8'd4);
        set_in(16'hA4A7, 3'd7);
        for (int l = 1; l <= 7; l++) bus(0, 6'(32 + l), 0);
        set_in('0, 3'd0);
        for (int l = 1; l <= 7; l++) bus(0, 6'(32 + l), 0);
        bus(1, 6'h11, 8'd15); bus(1, 6'h11, 8'd4); bus(1, 6'h12, 8'd0);
        // R11: single-cycle pulses show one edge later
        tag = "R11";
        set_in(16'h0100, 3'd0); set_in('0, 3'd0); set_in(16'h0004, 3'd0);
        set_in(16'h0004, 3'd6); set_in(16'h0001, 3'd6); idle(2);
        // R12: combinational wakeup
        tag = "R12";
        @(negedge clk); #1 lp_en = 1;
        set_in('0, 3'd0); set_in(16'h2000, 3'd2); set_in(16'h2000, 3'd1);
        set_in(16'h0001, 3'd7); set_in('0, 3'd7);
        @(negedge clk); #1 lp_en = 0; irq_src = 16'h0001;
        idle(2);
        // R7: random mix
        tag = "R7";
        for (int i = 0; i < 600; i++) begin
            @(negedge clk); #1;
            irq_src = 16'($urandom & $urandom & $urandom);
            core_mask = 3'($urandom);
            lp_en = 1'($urandom);
            if (($urandom % 4) == 0) begin
                sel = 1; wr = 1'($urandom);
                addr = {18'h3FFFF, 6'($urandom)};
                if (($urandom % 2) == 0) addr[5:0] = 6'h10 + 6'($urandom % 4);
                wdata = 8'($urandom % 20);
            end else begin
                sel = 0; wr = 0;
            end
        end
        @(negedge clk); #1 sel = 0; irq_src = '0;
        idle(3);
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule